// File: doc/BRIEF.md
# Arbitrated Bidirectional GPIO Port

This block is an eight-pin general-purpose I/O port whose pins can be claimed by three different owners. At the lowest priority, software owns the pins through a small register bus. It sets a direction mask and an output latch, and it reads the pin levels back through a synchronizer. A parallel slave port that is enabled by its own mode input takes the pins ahead of software. An external multiplexed address/data bus takes them ahead of both.

A single global pull-up enable drives the weak pull-up request of each pad. The request for a pin is suppressed whenever that pin is actually being driven, whichever owner drives it. The direction mask, the latch and the pull-up enable keep their values while a higher owner holds the pins. They take effect again as soon as that owner lets go.

Top module: `gpio_mux_port`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the direction register reads 0xFF, the latch reads 0x00, the control register reads 0x00, and with neither higher owner active pad_oe and pad_pu are both 0x00.
- R2: When software owns the pins, a direction bit of 0 drives the pin (pad_oe bit = 1) and a 1 leaves it as an input. For example, writing 0xCF to the direction register (address 2) gives pad_oe = 0x30.
- R3: When software owns the pins, pad_out equals the latch. A write to address 0 (port) or to address 1 (latch) loads the latch, and reading address 1 returns the latch contents.
- R4: A read of address 0 returns the pad levels after a two-flop synchronizer. A change on pad_in shows on reg_rdata after the second rising edge and not after the first.
- R5: The global pull-up enable is bit 0 of address 3. pad_pu[i] is 1 only when that bit is 1 and pin i is not driven (pad_oe[i] = 0).
- R6: With pp_en = 1 and xbus_en = 0, pad_out = pp_out and every pad_oe bit equals pp_oe. The direction and latch registers have no effect, and pp_in returns the synchronized pad levels.
- R7: With xbus_en = 1, pad_out = xbus_out and every pad_oe bit equals xbus_oe, whatever the values of pp_en and the direction register. xbus_in returns pad_in unsynchronized, in the same cycle.
- R8: Register writes are accepted while a higher owner holds the pins. When that owner releases the pins, pad_oe and pad_out follow the stored direction and latch at once.
- R9: Reading address 2 returns the direction register. Reading address 3 returns the pull-up enable in bit 0, with zeros in bits 7:1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 2 | Register address: 0 port, 1 latch, 2 direction, 3 control |
| reg_we | input | 1 | Write strobe, taken at the rising edge |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| pad_in | input | 8 | Pad input levels |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables, 1 = drive |
| pad_pu | output | 8 | Weak pull-up requests |
| xbus_en | input | 1 | External bus owns the pins |
| xbus_out | input | 8 | Address/data byte from the external bus |
| xbus_oe | input | 1 | External bus drives the pins |
| xbus_in | output | 8 | Raw pad levels to the external bus |
| pp_en | input | 1 | Parallel slave port owns the pins |
| pp_out | input | 8 | Parallel port output byte |
| pp_oe | input | 1 | Parallel port drives the pins |
| pp_in | output | 8 | Synchronized pad levels to the parallel port |

## Verification
Two pairs of events can fall in the same cycle here. The first is a register write to the direction or latch address while the external bus or the parallel port holds the pins. The second is both higher owners being enabled at once. The bench writes new direction and latch values while xbus_en is high and checks that the pads still follow the bus and that read-back shows the new values. It then drops xbus_en and checks that the stored values drive the pads in that same cycle. For the second case, pp_en is held high together with xbus_en, and the pads are expected to follow the bus alone.

// File: rtl/gpio_mux_pkg.sv
// Shared types for the arbitrated GPIO port.
// Assumes a two-bit register address space.
package gpio_mux_pkg;
    typedef enum logic [1:0] {
        OWN_REG = 2'd0,
        OWN_PP  = 2'd1,
        OWN_BUS = 2'd2
    } owner_e;

    localparam int unsigned ADDR_W = 2;
    localparam logic [ADDR_W-1:0] ADDR_PORT = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_LAT  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_DIR  = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_CTL  = 2'd3;
endpackage

// File: rtl/gpio_pin_sync.sv
// Multi-stage synchronizer for the pad input levels.
// Assumes STAGES >= 2. All stages clear on reset.
module gpio_pin_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pin_sync
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // First stage samples the asynchronous pads.
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= '0;
        else        stage_q[0] <= pad_in;
    end

    for (genvar k = 1; k < STAGES; k++) begin : g_stage
        // Each further stage retimes the stage before it.
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[k] <= '0;
            else        stage_q[k] <= stage_q[k-1];
        end
    end

    assign pin_sync = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_port_regs.sv
// Software-visible registers: latch, direction and pull-up enable.
// Writes land at the rising edge. The read mux is combinational.
// Assumes the address map in gpio_mux_pkg.
module gpio_port_regs
    import gpio_mux_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [WIDTH-1:0]  reg_wdata,
    input  logic [WIDTH-1:0]  pin_sync,
    output logic [WIDTH-1:0]  latch_q,
    output logic [WIDTH-1:0]  dir_q,
    output logic              pu_en_q,
    output logic [WIDTH-1:0]  reg_rdata
);
    logic wr_latch;
    assign wr_latch = reg_we && (reg_addr == ADDR_PORT || reg_addr == ADDR_LAT);

    // Output latch, loaded through either data address.
    always_ff @(posedge clk) begin
        if (!rst_n)        latch_q <= '0;
        else if (wr_latch) latch_q <= reg_wdata;
    end

    // Direction mask: ones are inputs, and every pin is an input after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                             dir_q <= '1;
        else if (reg_we && reg_addr == ADDR_DIR) dir_q <= reg_wdata;
    end

    // Global pull-up enable, off after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                             pu_en_q <= 1'b0;
        else if (reg_we && reg_addr == ADDR_CTL) pu_en_q <= reg_wdata[0];
    end

    // Read-back multiplexer.
    always_comb begin
        unique case (reg_addr)
            ADDR_PORT: reg_rdata = pin_sync;
            ADDR_LAT:  reg_rdata = latch_q;
            ADDR_DIR:  reg_rdata = dir_q;
            default:   reg_rdata = {{(WIDTH-1){1'b0}}, pu_en_q};
        endcase
    end
endmodule

// File: rtl/gpio_owner_mux.sv
// Pin ownership arbiter and per-pin pad drive.
// Priority is external bus, then parallel port, then registers.
// Pull-up requests are gated by the drive actually applied to each pad.
module gpio_owner_mux
    import gpio_mux_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             xbus_en,
    input  logic [WIDTH-1:0] xbus_out,
    input  logic             xbus_oe,
    input  logic             pp_en,
    input  logic [WIDTH-1:0] pp_out,
    input  logic             pp_oe,
    input  logic [WIDTH-1:0] latch_q,
    input  logic [WIDTH-1:0] dir_q,
    input  logic             pu_en_q,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_pu
);
    owner_e owner;

    // Select the owner by fixed priority.
    always_comb begin
        if (xbus_en)    owner = OWN_BUS;
        else if (pp_en) owner = OWN_PP;
        else            owner = OWN_REG;
    end

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        logic oe_w;
        assign oe_w = (owner == OWN_BUS) ? xbus_oe :
                      (owner == OWN_PP)  ? pp_oe   : ~dir_q[i];
        assign pad_oe[i]  = oe_w;
        assign pad_out[i] = (owner == OWN_BUS) ? xbus_out[i] :
                            (owner == OWN_PP)  ? pp_out[i]   : latch_q[i];
        assign pad_pu[i]  = pu_en_q & ~oe_w;
    end
endmodule

// File: rtl/gpio_mux_port.sv
// Top level of the arbitrated GPIO port.
// Joins the register file, the input synchronizer and the owner mux.
// Assumes rst_n is synchronous to clk.
module gpio_mux_port
    import gpio_mux_pkg::*;
#(
    parameter int unsigned WIDTH       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [WIDTH-1:0]  reg_wdata,
    output logic [WIDTH-1:0]  reg_rdata,
    input  logic [WIDTH-1:0]  pad_in,
    output logic [WIDTH-1:0]  pad_out,
    output logic [WIDTH-1:0]  pad_oe,
    output logic [WIDTH-1:0]  pad_pu,
    input  logic              xbus_en,
    input  logic [WIDTH-1:0]  xbus_out,
    input  logic              xbus_oe,
    output logic [WIDTH-1:0]  xbus_in,
    input  logic              pp_en,
    input  logic [WIDTH-1:0]  pp_out,
    input  logic              pp_oe,
    output logic [WIDTH-1:0]  pp_in
);
    logic [WIDTH-1:0] pin_sync;
    logic [WIDTH-1:0] latch_q;
    logic [WIDTH-1:0] dir_q;
    logic             pu_en_q;

    gpio_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pad_in   (pad_in),
        .pin_sync (pin_sync)
    );

    gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_we    (reg_we),
        .reg_wdata (reg_wdata),
        .pin_sync  (pin_sync),
        .latch_q   (latch_q),
        .dir_q     (dir_q),
        .pu_en_q   (pu_en_q),
        .reg_rdata (reg_rdata)
    );

    gpio_owner_mux #(.WIDTH(WIDTH)) u_mux (
        .xbus_en  (xbus_en),
        .xbus_out (xbus_out),
        .xbus_oe  (xbus_oe),
        .pp_en    (pp_en),
        .pp_out   (pp_out),
        .pp_oe    (pp_oe),
        .latch_q  (latch_q),
        .dir_q    (dir_q),
        .pu_en_q  (pu_en_q),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe),
        .pad_pu   (pad_pu)
    );

    // The bus samples raw pads on its own strobes. The parallel port gets retimed levels.
    assign xbus_in = pad_in;
    assign pp_in   = pin_sync;
endmodule

// File: rtl/gpio_mux_port_chk.sv
// Property checker for gpio_mux_port, attached with bind.
// Observes only the ports of the top module.
module gpio_mux_port_chk
    import gpio_mux_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_we,
    input logic [WIDTH-1:0]  reg_wdata,
    input logic [WIDTH-1:0]  reg_rdata,
    input logic [WIDTH-1:0]  pad_out,
    input logic [WIDTH-1:0]  pad_oe,
    input logic [WIDTH-1:0]  pad_pu,
    input logic              xbus_en,
    input logic [WIDTH-1:0]  xbus_out,
    input logic              xbus_oe,
    input logic              pp_en,
    input logic [WIDTH-1:0]  pp_out,
    input logic              pp_oe
);
    // R1: one cycle after reset, no pin is driven and no pull-up is requested.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (xbus_en || pp_en || (pad_oe == '0 && pad_pu == '0)));

    // R2: a direction write under register ownership sets the drive mask.
    a_r2_dir_to_oe: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == ADDR_DIR && !xbus_en && !pp_en)
        |=> (xbus_en || pp_en || pad_oe == ~$past(reg_wdata)));

    // R3: a data write is visible on the latch read-back next cycle.
    a_r3_latch_readback: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && (reg_addr == ADDR_LAT || reg_addr == ADDR_PORT))
        |=> (reg_addr != ADDR_LAT || reg_rdata == $past(reg_wdata)));

    // R5: a driven pin never requests a pull-up.
    a_r5_pu_off_when_driven: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_pu & pad_oe) == '0));

    // R6: the parallel port owns the pads when the bus is idle.
    a_r6_pp_owns: assert property (@(posedge clk) disable iff (!rst_n)
        (pp_en && !xbus_en) |-> (pad_out == pp_out && pad_oe == {WIDTH{pp_oe}}));

    // R7: the external bus wins over everything else.
    a_r7_bus_wins: assert property (@(posedge clk) disable iff (!rst_n)
        xbus_en |-> (pad_out == xbus_out && pad_oe == {WIDTH{xbus_oe}}));
endmodule

bind gpio_mux_port gpio_mux_port_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_we    (reg_we),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pad_pu    (pad_pu),
    .xbus_en   (xbus_en),
    .xbus_out  (xbus_out),
    .xbus_oe   (xbus_oe),
    .pp_en     (pp_en),
    .pp_out    (pp_out),
    .pp_oe     (pp_oe)
);

// File: tb/gpio_mux_port_tb.sv
// Scoreboard bench: driver tasks queue expected observations,
// and a monitor pops and compares them at each falling edge.
module gpio_mux_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] reg_addr = '0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] pad_in = '0;
    logic [7:0] pad_out, pad_oe, pad_pu;
    logic       xbus_en = 1'b0;
    logic [7:0] xbus_out = '0;
    logic       xbus_oe = 1'b0;
    logic [7:0] xbus_in;
    logic       pp_en = 1'b0;
    logic [7:0] pp_out = '0;
    logic       pp_oe = 1'b0;
    logic [7:0] pp_in;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    typedef enum int {S_RDATA, S_OUT, S_OE, S_PU, S_PPIN, S_XBIN} sel_e;
    typedef struct {
        string      req;
        sel_e       sel;
        logic [7:0] exp;
    } item_t;
    item_t sb_q[$];

    gpio_mux_port u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
        .xbus_en(xbus_en), .xbus_out(xbus_out), .xbus_oe(xbus_oe),
        .xbus_in(xbus_in), .pp_en(pp_en), .pp_out(pp_out), .pp_oe(pp_oe),
        .pp_in(pp_in)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] observe(sel_e s);
        case (s)
            S_RDATA: return reg_rdata;
            S_OUT:   return pad_out;
            S_OE:    return pad_oe;
            S_PU:    return pad_pu;
            S_PPIN:  return pp_in;
            default: return xbus_in;
        endcase
    endfunction

    // Monitor: compare queued expectations at the falling edge.
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it  = sb_q.pop_front();
            act = observe(it.sel);
            checks++;
            if (act !== it.exp) begin
                errors++;
                $display("FAIL %s %s: actual=%02h expected=%02h",
                         it.req, it.sel.name(), act, it.exp);
            end
        end
    end

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cycles, WATCHDOG);
            summary();
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_now(string req, sel_e s, logic [7:0] e);
        item_t it;
        it.req = req; it.sel = s; it.exp = e;
        sb_q.push_back(it);
        tick();
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        tick();
        reg_we = 1'b0;
    endtask

    task automatic rd(string req, logic [1:0] a, logic [7:0] e);
        reg_addr = a;
        expect_now(req, S_RDATA, e);
    endtask

    initial begin
        tick(); tick(); tick();
        rst_n = 1'b1;
        // R1 reset state
        expect_now("R1", S_OE, 8'h00);
        expect_now("R1", S_PU, 8'h00);
        rd("R1", 2'd2, 8'hFF);
        rd("R1", 2'd1, 8'h00);
        rd("R1", 2'd3, 8'h00);

        // R2 direction to drive mask
        wr(2'd2, 8'hCF);
        expect_now("R2", S_OE, 8'h30);
        // R3 latch through both addresses
        wr(2'd1, 8'hA5);
        expect_now("R3", S_OUT, 8'hA5);
        rd("R3", 2'd1, 8'hA5);
        wr(2'd0, 8'h3C);
        rd("R3", 2'd1, 8'h3C);
        wr(2'd0, 8'h00);
        rd("R3", 2'd1, 8'h00);

        // R5 pull-ups gated by drive
        wr(2'd3, 8'h01);
        expect_now("R5", S_PU, 8'hCF);
        wr(2'd2, 8'h0F);
        expect_now("R5", S_PU, 8'h0F);
        wr(2'd3, 8'h00);
        expect_now("R5", S_PU, 8'h00);
        wr(2'd3, 8'hFF);
        rd("R9", 2'd3, 8'h01);
        rd("R9", 2'd2, 8'h0F);

        // R4 two-stage synchronizer latency
        reg_addr = 2'd0;
        pad_in = 8'h5A;
        tick();
        expect_now("R4", S_RDATA, 8'h00);
        expect_now("R4", S_RDATA, 8'h5A);

        // R7 bus wins over parallel port and direction
        xbus_en = 1'b1; pp_en = 1'b1; xbus_out = 8'hE7; xbus_oe = 1'b1;
        pp_out = 8'h11; pp_oe = 1'b0;
        #1;
        expect_now("R7", S_OUT, 8'hE7);
        expect_now("R7", S_OE, 8'hFF);
        expect_now("R7", S_PU, 8'h00);
        xbus_oe = 1'b0; pad_in = 8'hC3;
        #1;
        expect_now("R7", S_OE, 8'h00);
        expect_now("R5", S_PU, 8'hFF);
        expect_now("R7", S_XBIN, 8'hC3);

        // R8 writes accepted while the bus holds the pins
        xbus_oe = 1'b1;
        wr(2'd2, 8'hF0);
        wr(2'd1, 8'h99);
        expect_now("R8", S_OUT, 8'hE7);
        rd("R8", 2'd2, 8'hF0);
        rd("R8", 2'd1, 8'h99);
        xbus_en = 1'b0; pp_en = 1'b0;
        #1;
        sb_q.push_back('{req: "R8", sel: S_OE, exp: 8'h0F});
        expect_now("R8", S_OUT, 8'h99);

        // R6 parallel port ownership
        pp_en = 1'b1; pp_out = 8'h3C; pp_oe = 1'b1;
        #1;
        expect_now("R6", S_OUT, 8'h3C);
        expect_now("R6", S_OE, 8'hFF);
        pp_oe = 1'b0;
        #1;
        expect_now("R6", S_OE, 8'h00);
        expect_now("R6", S_PPIN, 8'hC3);
        pp_en = 1'b0;
        tick();
        summary();
    end
endmodule